// File: doc/BRIEF.md
# Chiplet Attention Summary Aggregator

This block sits at the top of a chiplet's error-reporting tree. Seven child error collectors each report a checkstop summary and a recoverable summary. Children 1 to 6 also report a host-attention summary. The block places these lines at fixed, sparse positions in three 64-bit status views. It gates each view with a mask and drives one chiplet-level line for each attention class.

The status views are not latched. Each one reflects the child inputs live, so every output follows its inputs combinationally through the masks. The checkstop view and the recoverable view share one mask. The recoverable view is stored two positions above the checkstop view, so it is shifted down by two before masking. As a result, a child's recoverable line is gated by the same mask bit as its checkstop line. The special-attention view has its own mask. Software reaches the status views and both masks through a simple register port: a write strobe, an address and write data, with read data that follows the address combinationally.

Bit numbering in this brief is LSB-first: bit 63 is the most significant bit of a 64-bit register. Address offsets are the values on the 3-bit address port.

Top module: `cattn_summary`

## Requirements
- R1: The checkstop view (offset 0) shows child_xstop[0..6] at bits 60, 59, 56, 55, 54, 52 and 51 respectively. All other bits read zero.
- R2: The recoverable view (offset 1) shows child_recov[0..6] at bits 62, 61, 58, 57, 56, 54 and 53 respectively. All other bits read zero.
- R3: The special-attention view (offset 4) shows child_host[0..5], which belong to children 1..6, at bits 62, 59, 58, 57, 55 and 54. All other bits read zero.
- R4: After reset, both masks read all ones and all three attention outputs are low.
- R5: The shared mask (offset 2) and the special-attention mask (offset 7) are fully writable 64-bit registers. A write takes effect at the clock edge on which reg_wr is high, and each mask reads back the value last written to it.
- R6: xstop_attn is the OR of (checkstop view AND NOT shared mask), taken over bits 60..0 only.
- R7: recov_attn is the OR of ((recoverable view >> 2) AND NOT shared mask), taken over bits 60..0 only. Child k's recoverable line is therefore gated by the same mask bit as its checkstop line.
- R8: host_attn is the OR of (special-attention view AND NOT special-attention mask).
- R9: Writes to offsets 0, 1, 3, 4, 5 and 6 change nothing. A write to one mask leaves the other unchanged.
- R10: Offsets 3, 5 and 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| child_xstop | input | 7 | Checkstop summaries of children 0..6 |
| child_recov | input | 7 | Recoverable summaries of children 0..6 |
| child_host | input | 6 | Host-attention summaries of children 1..6 |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| xstop_attn | output | 1 | Chiplet checkstop attention |
| recov_attn | output | 1 | Chiplet recoverable attention |
| host_attn | output | 1 | Chiplet host attention |

## Verification
Some behaviours are checked on every cycle by the assertions. Each output must agree with a per-child gating computed from the raw child inputs and the mask state. Each mask must capture the data of a write to its own offset and hold its value otherwise. The unused offsets must read zero.

Other behaviours only the bench's scenarios can show. These are the exact bit positions in each view as read through the port, the reset value of the masks, and a recoverable line being gated by its partner checkstop bit rather than by its own stored position. The bench also covers a reset in the middle of the run that restores the masks after they were written.

// File: rtl/cattn_pkg.sv
package cattn_pkg;
  localparam int unsigned CHILDREN = 7;
  localparam int unsigned HOST_CHILDREN = CHILDREN - 1;

  // checkstop positions of children 0..6; the recoverable view adds the shift
  localparam int unsigned XS_POS [CHILDREN] = '{60, 59, 56, 55, 54, 52, 51};
  // host positions of children 1..6
  localparam int unsigned HOST_POS [HOST_CHILDREN] = '{62, 59, 58, 57, 55, 54};

  localparam int unsigned OFS_XSTOP   = 0;
  localparam int unsigned OFS_RECOV   = 1;
  localparam int unsigned OFS_MASK    = 2;
  localparam int unsigned OFS_SPA     = 4;
  localparam int unsigned OFS_SPAMASK = 7;
endpackage

// File: rtl/cattn_rst_sync.sv
module cattn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cattn_scatter.sv
module cattn_scatter #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_IN   = 7,
  parameter int unsigned OFFSET = 0,
  parameter int unsigned POS [N_IN] = '{default: 0}
) (
  input  logic [N_IN-1:0]   bits_in,
  output logic [DATA_W-1:0] view
);
  logic [DATA_W-1:0] parts [N_IN];

  for (genvar i = 0; i < N_IN; i++) begin : g_place
    localparam int unsigned P = POS[i] + OFFSET;
    assign parts[i] = DATA_W'(bits_in[i]) << P;
  end

  always_comb begin
    view = '0;
    for (int i = 0; i < int'(N_IN); i++) view = view | parts[i];
  end
endmodule

// File: rtl/cattn_mask_reg.sv
module cattn_mask_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/cattn_reduce.sv
module cattn_reduce #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned SHIFT    = 0,
  parameter int unsigned TOP_EXCL = 0
) (
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  output logic              attn
);
  localparam logic [DATA_W-1:0] KEEP = {DATA_W{1'b1}} >> TOP_EXCL;
  logic [DATA_W-1:0] aligned;

  if (SHIFT > 0) begin : g_shift
    assign aligned = status >> SHIFT;
  end else begin : g_direct
    assign aligned = status;
  end

  assign attn = |(aligned & ~mask & KEEP);
endmodule

// File: rtl/cattn_summary.sv
module cattn_summary #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned REC_SHIFT = 2,
  parameter int unsigned TOP_EXCL  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [cattn_pkg::CHILDREN-1:0]      child_xstop,
  input  logic [cattn_pkg::CHILDREN-1:0]      child_recov,
  input  logic [cattn_pkg::HOST_CHILDREN-1:0] child_host,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      xstop_attn,
  output logic                      recov_attn,
  output logic                      host_attn
);
  import cattn_pkg::*;

  logic              rst_sync_n;
  logic [DATA_W-1:0] xs_view, rc_view, spa_view;
  logic [DATA_W-1:0] err_mask_q, spa_mask_q;
  logic              wr_err_mask, wr_spa_mask;

  cattn_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cattn_scatter #(.DATA_W(DATA_W), .N_IN(CHILDREN), .OFFSET(0), .POS(XS_POS))
    u_xs_map (.bits_in(child_xstop), .view(xs_view));
  cattn_scatter #(.DATA_W(DATA_W), .N_IN(CHILDREN), .OFFSET(REC_SHIFT), .POS(XS_POS))
    u_rc_map (.bits_in(child_recov), .view(rc_view));
  cattn_scatter #(.DATA_W(DATA_W), .N_IN(HOST_CHILDREN), .OFFSET(0), .POS(HOST_POS))
    u_spa_map (.bits_in(child_host), .view(spa_view));

  assign wr_err_mask = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));
  assign wr_spa_mask = reg_wr && (reg_addr == ADDR_W'(OFS_SPAMASK));

  cattn_mask_reg #(.DATA_W(DATA_W)) u_err_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_err_mask),
    .wdata(reg_wdata), .mask_q(err_mask_q));
  cattn_mask_reg #(.DATA_W(DATA_W)) u_spa_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_spa_mask),
    .wdata(reg_wdata), .mask_q(spa_mask_q));

  cattn_reduce #(.DATA_W(DATA_W), .SHIFT(0), .TOP_EXCL(TOP_EXCL))
    u_xs_red (.status(xs_view), .mask(err_mask_q), .attn(xstop_attn));
  cattn_reduce #(.DATA_W(DATA_W), .SHIFT(REC_SHIFT), .TOP_EXCL(TOP_EXCL))
    u_rc_red (.status(rc_view), .mask(err_mask_q), .attn(recov_attn));
  cattn_reduce #(.DATA_W(DATA_W), .SHIFT(0), .TOP_EXCL(0))
    u_spa_red (.status(spa_view), .mask(spa_mask_q), .attn(host_attn));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_XSTOP):   reg_rdata = xs_view;
      ADDR_W'(OFS_RECOV):   reg_rdata = rc_view;
      ADDR_W'(OFS_MASK):    reg_rdata = err_mask_q;
      ADDR_W'(OFS_SPA):     reg_rdata = spa_view;
      ADDR_W'(OFS_SPAMASK): reg_rdata = spa_mask_q;
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cattn_sum_chk.sv
module cattn_sum_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 3
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic [cattn_pkg::CHILDREN-1:0]      child_xstop,
  input logic [cattn_pkg::CHILDREN-1:0]      child_recov,
  input logic [cattn_pkg::HOST_CHILDREN-1:0] child_host,
  input logic                      reg_wr,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic [DATA_W-1:0]         reg_rdata,
  input logic                      xstop_attn,
  input logic                      recov_attn,
  input logic                      host_attn,
  input logic [DATA_W-1:0]         err_mask_q,
  input logic [DATA_W-1:0]         spa_mask_q
);
  import cattn_pkg::*;

  logic xs_ref, rc_ref, host_ref;

  always_comb begin
    xs_ref = 1'b0;
    rc_ref = 1'b0;
    host_ref = 1'b0;
    for (int i = 0; i < int'(CHILDREN); i++) begin
      xs_ref = xs_ref | (child_xstop[i] & ~err_mask_q[XS_POS[i]]);
      rc_ref = rc_ref | (child_recov[i] & ~err_mask_q[XS_POS[i]]);
    end
    for (int i = 0; i < int'(HOST_CHILDREN); i++)
      host_ref = host_ref | (child_host[i] & ~spa_mask_q[HOST_POS[i]]);
  end

  // R6
  xstop_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xstop_attn == xs_ref);
  // R7
  recov_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    recov_attn == rc_ref);
  // R8
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_attn == host_ref);
  // R5
  err_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_MASK)) |=> err_mask_q == $past(reg_wdata));
  // R5
  spa_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_SPAMASK)) |=> spa_mask_q == $past(reg_wdata));
  // R9
  err_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr && reg_addr == ADDR_W'(OFS_MASK)) |=> $stable(err_mask_q));
  // R9
  spa_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr && reg_addr == ADDR_W'(OFS_SPAMASK)) |=> $stable(spa_mask_q));
  // R10
  unused_ofs_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == 3'd3 || reg_addr == 3'd5 || reg_addr == 3'd6) |-> reg_rdata == '0);
endmodule

bind cattn_summary cattn_sum_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .child_xstop(child_xstop), .child_recov(child_recov), .child_host(child_host),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .xstop_attn(xstop_attn), .recov_attn(recov_attn), .host_attn(host_attn),
  .err_mask_q(err_mask_q), .spa_mask_q(spa_mask_q));

// File: tb/sim_cattn_summary.sv
module sim_cattn_summary;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  child_xstop = '0;
  logic [6:0]  child_recov = '0;
  logic [5:0]  child_host = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        xstop_attn, recov_attn, host_attn;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  cattn_summary u0 (
    .clk(clk), .rst_n(rst_n), .child_xstop(child_xstop), .child_recov(child_recov),
    .child_host(child_host), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xstop_attn(xstop_attn),
    .recov_attn(recov_attn), .host_attn(host_attn));

  localparam int XP [7] = '{60, 59, 56, 55, 54, 52, 51};
  localparam int HP [6] = '{62, 59, 58, 57, 55, 54};
  localparam logic [63:0] ONES = '1;

  function automatic logic [63:0] xs_exp(input logic [6:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 7; i++) r[XP[i]] = v[i];
    return r;
  endfunction
  function automatic logic [63:0] rc_exp(input logic [6:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 7; i++) r[XP[i] + 2] = v[i];
    return r;
  endfunction
  function automatic logic [63:0] sa_exp(input logic [5:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 6; i++) r[HP[i]] = v[i];
    return r;
  endfunction

  typedef struct packed {
    logic [6:0]  xs;
    logic [6:0]  rc;
    logic [5:0]  h;
    logic [63:0] m;
    logic [63:0] sm;
    logic        ex;
    logic        er;
    logic        eh;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h01, 7'h00, 6'h00, ~(64'd1 << 60), ONES, 1'b1, 1'b0, 1'b0},
    '{7'h02, 7'h01, 6'h00, ~(64'd1 << 60), ONES, 1'b0, 1'b1, 1'b0},
    '{7'h00, 7'h40, 6'h01, ~(64'd1 << 51), ~(64'd1 << 62), 1'b0, 1'b1, 1'b1},
    '{7'h7F, 7'h7F, 6'h3F, ONES, ONES, 1'b0, 1'b0, 1'b0},
    '{7'h40, 7'h00, 6'h20, 64'd0, ~(64'd1 << 55), 1'b1, 1'b0, 1'b0},
    '{7'h00, 7'h10, 6'h20, ~(64'd1 << 54), 64'd0, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [63:0] d;
    do_reset();
    // R4 reset state
    rd(3'd2, d); check("R4 err mask reset", d, ONES);
    rd(3'd7, d); check("R4 spa mask reset", d, ONES);
    child_xstop = 7'h7F; child_recov = 7'h7F; child_host = 6'h3F;
    #1 check("R4 outputs low", {61'd0, xstop_attn, recov_attn, host_attn}, 64'd0);
    child_xstop = '0; child_recov = '0; child_host = '0;

    // table walk: R1 R2 R3 R6 R7 R8
    for (int k = 0; k < 6; k++) begin
      wr(3'd2, VECS[k].m);
      wr(3'd7, VECS[k].sm);
      child_xstop = VECS[k].xs; child_recov = VECS[k].rc; child_host = VECS[k].h;
      rd(3'd0, d); check("R1 checkstop view", d, xs_exp(VECS[k].xs));
      rd(3'd1, d); check("R2 recoverable view", d, rc_exp(VECS[k].rc));
      rd(3'd4, d); check("R3 special view", d, sa_exp(VECS[k].h));
      check("R6 xstop_attn", {63'd0, xstop_attn}, {63'd0, VECS[k].ex});
      check("R7 recov_attn", {63'd0, recov_attn}, {63'd0, VECS[k].er});
      check("R8 host_attn", {63'd0, host_attn}, {63'd0, VECS[k].eh});
    end

    // R1 single child positions
    for (int i = 0; i < 7; i++) begin
      child_xstop = 7'(1 << i);
      rd(3'd0, d); check("R1 single child", d, 64'd1 << XP[i]);
    end
    child_xstop = '0;

    // R5 mask read/write
    wr(3'd2, 64'hA5A5_0F0F_1234_5678);
    rd(3'd2, d); check("R5 err mask rw", d, 64'hA5A5_0F0F_1234_5678);
    wr(3'd7, 64'h5A5A_F0F0_8765_4321);
    rd(3'd7, d); check("R5 spa mask rw", d, 64'h5A5A_F0F0_8765_4321);
    // R9 one mask write leaves the other alone
    rd(3'd2, d); check("R9 err mask untouched", d, 64'hA5A5_0F0F_1234_5678);

    // R9 writes to other offsets change nothing
    child_xstop = 7'h05; child_recov = 7'h0A; child_host = 6'h11;
    wr(3'd0, ONES); wr(3'd1, ONES); wr(3'd3, ONES);
    wr(3'd4, ONES); wr(3'd5, ONES); wr(3'd6, ONES);
    rd(3'd0, d); check("R9 checkstop after write", d, xs_exp(7'h05));
    rd(3'd1, d); check("R9 recoverable after write", d, rc_exp(7'h0A));
    rd(3'd4, d); check("R9 special after write", d, sa_exp(6'h11));
    rd(3'd2, d); check("R9 err mask kept", d, 64'hA5A5_0F0F_1234_5678);
    rd(3'd7, d); check("R9 spa mask kept", d, 64'h5A5A_F0F0_8765_4321);

    // R10 unused offsets
    rd(3'd3, d); check("R10 offset 3", d, 64'd0);
    rd(3'd5, d); check("R10 offset 5", d, 64'd0);
    rd(3'd6, d); check("R10 offset 6", d, 64'd0);

    // R7 recoverable gated by partner checkstop bit, not its own stored bit
    wr(3'd2, ~(64'd1 << 62));
    child_xstop = '0; child_recov = 7'h01;
    #1 check("R7 own-position unmask ignored", {63'd0, recov_attn}, 64'd0);
    wr(3'd2, ~(64'd1 << 60));
    #1 check("R7 partner unmask", {63'd0, recov_attn}, 64'd1);
    // R6 top bits excluded: unmask only 63:61, all checkstops high
    wr(3'd2, 64'h1FFF_FFFF_FFFF_FFFF);
    child_xstop = 7'h7F; child_recov = '0;
    #1 check("R6 top bits excluded", {63'd0, xstop_attn}, 64'd0);

    // R4 reset mid-run restores masks
    do_reset();
    rd(3'd2, d); check("R4 err mask after reset", d, ONES);
    rd(3'd7, d); check("R4 spa mask after reset", d, ONES);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule